// File: doc/BRIEF.md
# Programmable Periodic and One-Shot Countdown Timer

This block is a down-counter that loses one unit on every tick of an internal tick source. The tick spacing is set by an integer number of clock cycles plus a 32-bit binary fraction of a cycle. The fractional residue accumulates, so the average tick spacing equals the programmed value. The counter can run in periodic mode, where it reloads from a limit value on every expiry. It can also run in one-shot mode, where it stops at expiry. Each expiry produces a single-cycle trigger pulse.

A small command port controls the timer. Through it the owner starts and stops the timer, writes the count, writes the limit (with an option to load it into the count at once), and programs the tick period. The live count and mode are visible on output ports at all times. A static policy input makes the counter rest at zero for one extra tick interval before a periodic reload.

Top module: `cdt_timer`

## Requirements
- R1: After synchronous reset, mode_o is 0 (disabled), count_o is 0 and trigger_o is 0. The mode code is 0 for disabled, 1 for periodic and 2 for one-shot. Limit and period also reset to zero.
- R2: A run command (cmd_op 1) issued while disabled, with an integer period of zero, is ignored and the mode stays 0.
- R3: When running with period integer P and fraction zero, count_o drops by one every P clocks. The first drop comes P clock edges after the edge that accepted the run.
- R4: In periodic mode, the tick that finds count 1 makes trigger_o high for exactly one cycle. On that same update count_o becomes the limit and the mode stays 1.
- R5: In one-shot mode (run with cmd_flag 1), the tick that finds count 1 raises trigger_o for one cycle, sets count_o to 0 and returns the mode to 0.
- R6: With wrap_hold high, a periodic expiry raises the trigger and shows count 0 for one whole tick interval. The next tick then loads the limit, with no second trigger.
- R7: A stop command (cmd_op 2) sets the mode to 0 and freezes count_o. A later run resumes from the frozen count with a fresh tick phase.
- R8: A limit write (cmd_op 4) with cmd_flag 0 leaves count_o unchanged. With cmd_flag 1 it also loads count_o with the new limit on the next edge.
- R9: A count write (cmd_op 3) loads count_o on the next edge. If the timer is running, the tick phase restarts from that edge.
- R10: With period integer P and fraction F (a value out of 2^32), the k-th tick after a run falls k*P + floor(k*F/2^32) edges after the run edge.
- R11: When a restart finds count 0, the trigger fires and the limit is loaded. If the loaded value is zero, the timer disables itself instead.
- R12: A period write (cmd_op 5, integer on cmd_data, fraction on cmd_frac) while running keeps the count and restarts the tick phase. If the new integer is zero, the timer disables itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_op | input | 3 | Command: 0 idle, 1 run, 2 stop, 3 write count, 4 write limit, 5 write period |
| cmd_flag | input | 1 | Run: one-shot select; write limit: load count now |
| cmd_data | input | CNT_W | Count, limit or integer period value |
| cmd_frac | input | FRAC_W | Fractional period for a period write |
| wrap_hold | input | 1 | Hold zero for one tick before a periodic reload |
| count_o | output | CNT_W | Present count |
| mode_o | output | 2 | 0 disabled, 1 periodic, 2 one-shot |
| trigger_o | output | 1 | One-cycle pulse on each expiry |

## Verification
A wrong phase counter or fractional accumulator moves count_o transitions earlier or later. The error shows at the first tick after a run, or within a few ticks once the carries pile up, so the bench compares count_o on every cycle against tick times computed from the closed formula. A corrupted hold or mode state shows either as a trigger on the wrong cycle or as a missing return to mode 0. It appears at the expiry itself or one tick interval later. A dropped command-priority rule shows on the edge right after the colliding command.

// File: rtl/cdt_pkg.sv
package cdt_pkg;

   typedef enum logic [1:0] {
      MD_OFF      = 2'd0,
      MD_PERIODIC = 2'd1,
      MD_ONESHOT  = 2'd2
   } mode_e;

   localparam logic [2:0] OP_IDLE   = 3'd0;
   localparam logic [2:0] OP_RUN    = 3'd1;
   localparam logic [2:0] OP_STOP   = 3'd2;
   localparam logic [2:0] OP_COUNT  = 3'd3;
   localparam logic [2:0] OP_LIMIT  = 3'd4;
   localparam logic [2:0] OP_PERIOD = 3'd5;

endpackage

// File: rtl/cdt_period_store.sv
module cdt_period_store #(
   parameter int PER_W  = 16,
   parameter int FRAC_W = 32
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              we_i,
   input  logic [PER_W-1:0]  int_i,
   input  logic [FRAC_W-1:0] frac_i,
   output logic [PER_W-1:0]  per_int_o,
   output logic [FRAC_W-1:0] per_frac_o,
   output logic              per_zero_o
);

   logic [PER_W-1:0]  int_q;
   logic [FRAC_W-1:0] frac_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         int_q  <= '0;
         frac_q <= '0;
      end else if (we_i) begin
         int_q  <= int_i;
         frac_q <= frac_i;
      end
   end

   assign per_int_o  = int_q;
   assign per_frac_o = frac_q;
   assign per_zero_o = (int_q == '0);

endmodule

// File: rtl/cdt_tick_gen.sv
module cdt_tick_gen #(
   parameter int PER_W   = 16,
   parameter int FRAC_W  = 32,
   parameter bit FRAC_EN = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              run_en_i,
   input  logic              restart_i,
   input  logic [PER_W-1:0]  per_int_i,
   input  logic [FRAC_W-1:0] per_frac_i,
   output logic              tick_o
);

   localparam int CYC_W = PER_W + 1;

   if (FRAC_W < 1) begin : g_bad_frac
      $error("cdt_tick_gen: FRAC_W must be at least 1");
   end

   logic [CYC_W-1:0] cyc_q;
   logic [CYC_W-1:0] last_cyc;
   logic             carry;
   logic             hit;
   logic             clear;

   assign clear = rst_i || !run_en_i || restart_i;

   if (FRAC_EN) begin : g_frac
      logic [FRAC_W-1:0] acc_q;
      logic [FRAC_W-1:0] acc_sum;

      assign {carry, acc_sum} = {1'b0, acc_q} + {1'b0, per_frac_i};

      always_ff @(posedge clk_i) begin
         if (clear)    acc_q <= '0;
         else if (hit) acc_q <= acc_sum;
      end
   end else begin : g_int
      logic unused_frac;
      assign unused_frac = ^per_frac_i;
      assign carry = 1'b0;
   end

   assign last_cyc = ({1'b0, per_int_i} + CYC_W'(carry)) - CYC_W'(1);
   assign hit      = run_en_i && (cyc_q == last_cyc);
   assign tick_o   = hit;

   always_ff @(posedge clk_i) begin
      if (clear)    cyc_q <= '0;
      else if (hit) cyc_q <= '0;
      else          cyc_q <= cyc_q + CYC_W'(1);
   end

endmodule

// File: rtl/cdt_count_core.sv
module cdt_count_core
   import cdt_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic [2:0]       op_i,
   input  logic             flag_i,
   input  logic [CNT_W-1:0] data_i,
   input  logic             new_per_zero_i,
   input  logic             per_zero_i,
   input  logic             tick_i,
   input  logic             wrap_hold_i,
   output logic [CNT_W-1:0] cnt_o,
   output mode_e            mode_o,
   output logic             trig_o,
   output logic             restart_o,
   output logic             run_en_o
);

   mode_e            mode_q, mode_n, tk_mode;
   logic [CNT_W-1:0] cnt_q, cnt_n, tk_cnt;
   logic [CNT_W-1:0] lim_q, lim_n;
   logic             hold_q, hold_n, tk_hold;
   logic             trig_q, trig_n, tk_trig;
   logic             running;
   logic             do_start;
   logic [CNT_W-1:0] st_val, st_lim, st_fill;
   logic             st_pz;
   mode_e            run_mode;

   assign running  = (mode_q != MD_OFF);
   assign run_mode = flag_i ? MD_ONESHOT : MD_PERIODIC;

   // tick outcome, used when the command does not override it
   always_comb begin
      tk_mode = mode_q;
      tk_cnt  = cnt_q;
      tk_hold = hold_q;
      tk_trig = 1'b0;
      if (tick_i && running) begin
         if (hold_q) begin
            tk_hold = 1'b0;
            tk_cnt  = lim_q;
            if (lim_q == '0) tk_mode = MD_OFF;
         end else if (cnt_q <= CNT_W'(1)) begin
            tk_trig = 1'b1;
            tk_cnt  = '0;
            if (mode_q == MD_ONESHOT || lim_q == '0) tk_mode = MD_OFF;
            else if (wrap_hold_i)                   tk_hold = 1'b1;
            else                                    tk_cnt  = lim_q;
         end else begin
            tk_cnt = cnt_q - CNT_W'(1);
         end
      end
   end

   // command resolution and restart evaluation
   always_comb begin
      mode_n    = tk_mode;
      cnt_n     = tk_cnt;
      hold_n    = tk_hold;
      trig_n    = tk_trig;
      lim_n     = lim_q;
      do_start  = 1'b0;
      st_val    = cnt_q;
      st_lim    = lim_q;
      st_pz     = per_zero_i;
      restart_o = 1'b0;
      st_fill   = '0;
      case (op_i)
         OP_RUN: begin
            if (!running) begin
               if (!per_zero_i) begin
                  mode_n   = run_mode;
                  do_start = 1'b1;
               end
            end else if (tk_mode != MD_OFF) begin
               mode_n = run_mode;
            end
         end
         OP_STOP: begin
            mode_n = MD_OFF;
            cnt_n  = cnt_q;
            hold_n = 1'b0;
            trig_n = 1'b0;
         end
         OP_COUNT: begin
            mode_n   = mode_q;
            cnt_n    = data_i;
            hold_n   = 1'b0;
            trig_n   = 1'b0;
            do_start = running;
            st_val   = data_i;
         end
         OP_LIMIT: begin
            lim_n = data_i;
            if (flag_i) begin
               mode_n   = mode_q;
               cnt_n    = data_i;
               hold_n   = 1'b0;
               trig_n   = 1'b0;
               do_start = running;
               st_val   = data_i;
               st_lim   = data_i;
            end
         end
         OP_PERIOD: begin
            mode_n   = mode_q;
            cnt_n    = cnt_q;
            hold_n   = 1'b0;
            trig_n   = 1'b0;
            do_start = running;
            st_pz    = new_per_zero_i;
         end
         default: ;
      endcase
      if (do_start) begin
         st_fill = (st_val == '0) ? st_lim : st_val;
         trig_n  = (st_val == '0);
         cnt_n   = st_fill;
         hold_n  = 1'b0;
         if (st_fill == '0 || st_pz) mode_n = MD_OFF;
         else                        restart_o = 1'b1;
      end
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         mode_q <= MD_OFF;
         cnt_q  <= '0;
         lim_q  <= '0;
         hold_q <= 1'b0;
         trig_q <= 1'b0;
      end else begin
         mode_q <= mode_n;
         cnt_q  <= cnt_n;
         lim_q  <= lim_n;
         hold_q <= hold_n;
         trig_q <= trig_n;
      end
   end

   assign cnt_o    = cnt_q;
   assign mode_o   = mode_q;
   assign trig_o   = trig_q;
   assign run_en_o = running;

   // R1
   reset_state_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      $past(rst_i) |-> (mode_q == MD_OFF && cnt_q == '0 && !trig_q));

   // R2
   zero_period_run_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (!running && per_zero_i && op_i == OP_RUN) |=> (mode_q == MD_OFF));

   // R3
   count_step_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (running && op_i == OP_IDLE && tick_i && !hold_q && cnt_q > CNT_W'(1))
      |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

   // R5
   oneshot_end_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (mode_q == MD_ONESHOT && op_i == OP_IDLE && tick_i && !hold_q && cnt_q == CNT_W'(1))
      |=> (mode_q == MD_OFF && trig_q && cnt_q == '0));

   // R6
   hold_zero_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      hold_q |-> (cnt_q == '0));

   // R7
   stop_freeze_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (op_i == OP_STOP) |=> (mode_q == MD_OFF && cnt_q == $past(cnt_q)));

endmodule

// File: rtl/cdt_timer.sv
module cdt_timer
   import cdt_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter int PER_W   = 16,
   parameter int FRAC_W  = 32,
   parameter bit FRAC_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [2:0]        cmd_op,
   input  logic              cmd_flag,
   input  logic [CNT_W-1:0]  cmd_data,
   input  logic [FRAC_W-1:0] cmd_frac,
   input  logic              wrap_hold,
   output logic [CNT_W-1:0]  count_o,
   output logic [1:0]        mode_o,
   output logic              trigger_o
);

   if (PER_W > CNT_W) begin : g_bad_width
      $error("cdt_timer: PER_W must not exceed CNT_W");
   end
   if (CNT_W < 2) begin : g_bad_cnt
      $error("cdt_timer: CNT_W must be at least 2");
   end

   logic [PER_W-1:0]  per_int;
   logic [FRAC_W-1:0] per_frac;
   logic              per_zero;
   logic              new_per_zero;
   logic              tick;
   logic              restart;
   logic              run_en;
   mode_e             mode_w;

   assign new_per_zero = (cmd_data[PER_W-1:0] == '0);

   cdt_period_store #(.PER_W(PER_W), .FRAC_W(FRAC_W)) u_per (
      .clk_i      (clk),
      .rst_i      (rst),
      .we_i       (cmd_op == OP_PERIOD),
      .int_i      (cmd_data[PER_W-1:0]),
      .frac_i     (cmd_frac),
      .per_int_o  (per_int),
      .per_frac_o (per_frac),
      .per_zero_o (per_zero)
   );

   cdt_tick_gen #(.PER_W(PER_W), .FRAC_W(FRAC_W), .FRAC_EN(FRAC_EN)) u_tick (
      .clk_i      (clk),
      .rst_i      (rst),
      .run_en_i   (run_en),
      .restart_i  (restart),
      .per_int_i  (per_int),
      .per_frac_i (per_frac),
      .tick_o     (tick)
   );

   cdt_count_core #(.CNT_W(CNT_W)) u_core (
      .clk_i          (clk),
      .rst_i          (rst),
      .op_i           (cmd_op),
      .flag_i         (cmd_flag),
      .data_i         (cmd_data),
      .new_per_zero_i (new_per_zero),
      .per_zero_i     (per_zero),
      .tick_i         (tick),
      .wrap_hold_i    (wrap_hold),
      .cnt_o          (count_o),
      .mode_o         (mode_w),
      .trig_o         (trigger_o),
      .restart_o      (restart),
      .run_en_o       (run_en)
   );

   assign mode_o = mode_w;

endmodule

// File: tb/cdt_timer_bench.sv
module cdt_timer_bench;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [2:0]  cmd_op = '0;
   logic        cmd_flag = 1'b0;
   logic [15:0] cmd_data = '0;
   logic [31:0] cmd_frac = '0;
   logic        wrap_hold = 1'b0;
   logic [15:0] count_o;
   logic [1:0]  mode_o;
   logic        trigger_o;

   int n_cmp = 0;
   int n_bad = 0;

   // reference state
   longint unsigned e_now, m_r, m_k, m_P, m_F;
   int unsigned m_mode, m_cnt, m_lim;
   bit m_hold, m_trig;

   always #10 clk = ~clk;

   cdt_timer u_cdt_timer (
      .clk(clk), .rst(rst), .cmd_op(cmd_op), .cmd_flag(cmd_flag),
      .cmd_data(cmd_data), .cmd_frac(cmd_frac), .wrap_hold(wrap_hold),
      .count_o(count_o), .mode_o(mode_o), .trigger_o(trigger_o)
   );

   task automatic chk(input string tag, input longint act, input longint exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // expected edge of the next tick, from the closed formula of R10
   function automatic longint unsigned next_tick_edge();
      longint unsigned k1 = m_k + 1;
      return m_r + k1 * m_P + ((k1 * m_F) >> 32);
   endfunction

   // R11/R12 restart evaluation
   task automatic m_start(input int unsigned v, input int unsigned lim, input bit pz);
      int unsigned fill = (v == 0) ? lim : v;
      m_trig = (v == 0);
      m_cnt  = fill;
      m_hold = 1'b0;
      if (fill == 0 || pz) m_mode = 0;
      else begin m_r = e_now; m_k = 0; end
   endtask

   task automatic model_edge(input int op, input bit fl, input int unsigned d, input longint unsigned fr);
      bit tick;
      int unsigned t_mode, t_cnt;
      bit t_hold, t_trig;
      bit running = (m_mode != 0);
      bit pz = (m_P == 0);
      e_now++;
      tick = running && (e_now == next_tick_edge());
      t_mode = m_mode; t_cnt = m_cnt; t_hold = m_hold; t_trig = 1'b0;
      if (tick) begin
         if (m_hold) begin
            t_hold = 1'b0; t_cnt = m_lim;
            if (m_lim == 0) t_mode = 0;
         end else if (m_cnt <= 1) begin
            t_trig = 1'b1; t_cnt = 0;
            if (m_mode == 2 || m_lim == 0) t_mode = 0;
            else if (wrap_hold) t_hold = 1'b1;
            else t_cnt = m_lim;
         end else t_cnt = m_cnt - 1;
      end
      case (op)
         1: begin
            if (!running) begin
               m_trig = 1'b0;
               if (!pz) begin m_mode = fl ? 2 : 1; m_start(m_cnt, m_lim, 1'b0); end
            end else begin
               m_cnt = t_cnt; m_hold = t_hold; m_trig = t_trig; m_mode = t_mode;
               if (tick) m_k++;
               if (t_mode != 0) m_mode = fl ? 2 : 1;
            end
         end
         2: begin m_mode = 0; m_hold = 1'b0; m_trig = 1'b0; end
         3: begin
            m_cnt = d; m_hold = 1'b0; m_trig = 1'b0;
            if (running) m_start(d, m_lim, pz);
         end
         4: begin
            if (!fl) begin
               m_cnt = t_cnt; m_hold = t_hold; m_trig = t_trig; m_mode = t_mode;
               if (tick) m_k++;
               m_lim = d;
            end else begin
               m_lim = d; m_cnt = d; m_hold = 1'b0; m_trig = 1'b0;
               if (running) m_start(d, d, pz);
            end
         end
         5: begin
            m_P = d; m_F = fr; m_hold = 1'b0; m_trig = 1'b0;
            if (running) m_start(m_cnt, m_lim, d == 0);
         end
         default: begin
            m_cnt = t_cnt; m_hold = t_hold; m_trig = t_trig; m_mode = t_mode;
            if (tick) m_k++;
         end
      endcase
   endtask

   task automatic step(input int op, input bit fl, input int unsigned d, input longint unsigned fr);
      cmd_op = 3'(op); cmd_flag = fl; cmd_data = 16'(d); cmd_frac = 32'(fr);
      model_edge(op, fl, d, fr);
      @(negedge clk);
      chk("R3 count", longint'(count_o), longint'(m_cnt));
      chk("R5 mode", longint'(mode_o), longint'(m_mode));
      chk("R4 trigger", longint'(trigger_o), longint'(m_trig));
      cmd_op = '0; cmd_flag = 1'b0; cmd_data = '0; cmd_frac = '0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(0, 0, 0, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      int unsigned seed;
      seed = $urandom(32'h00C0_FFEE);
      repeat (3) @(negedge clk);
      rst = 1'b0;
      e_now = 0; m_r = 0; m_k = 0; m_P = 0; m_F = 0;
      m_mode = 0; m_cnt = 0; m_lim = 0; m_hold = 0; m_trig = 0;
      // R1 reset state
      chk("R1 mode", longint'(mode_o), 0);
      chk("R1 count", longint'(count_o), 0);
      chk("R1 trigger", longint'(trigger_o), 0);
      // R2 run ignored with zero period
      step(1, 0, 0, 0);
      chk("R2 mode", longint'(mode_o), 0);
      // R8 limit without and with reload
      step(5, 0, 2, 0);
      step(4, 0, 4, 0);
      chk("R8 no reload", longint'(count_o), 0);
      step(4, 1, 3, 0);
      chk("R8 reload", longint'(count_o), 3);
      // R3 / R4 periodic, P=2
      step(1, 0, 0, 0);
      idle(2);
      chk("R3 first drop", longint'(count_o), 2);
      idle(4);
      chk("R4 reload", longint'(count_o), 3);
      chk("R4 pulse", longint'(trigger_o), 1);
      idle(1);
      chk("R4 single cycle", longint'(trigger_o), 0);
      chk("R4 mode kept", longint'(mode_o), 1);
      // R7 stop and resume
      step(2, 0, 0, 0);
      chk("R7 frozen", longint'(count_o), 3);
      idle(5);
      chk("R7 still frozen", longint'(count_o), 3);
      step(1, 1, 0, 0);
      idle(2);
      chk("R7 resumed", longint'(count_o), 2);
      // R5 one-shot end
      idle(4);
      chk("R5 count", longint'(count_o), 0);
      chk("R5 mode off", longint'(mode_o), 0);
      chk("R5 pulse", longint'(trigger_o), 1);
      // R6 wrap hold
      wrap_hold = 1'b1;
      step(4, 1, 2, 0);
      step(1, 0, 0, 0);
      idle(4);
      chk("R6 expiry", longint'(count_o), 0);
      chk("R6 pulse", longint'(trigger_o), 1);
      idle(1);
      chk("R6 held zero", longint'(count_o), 0);
      idle(1);
      chk("R6 reload", longint'(count_o), 2);
      chk("R6 no second pulse", longint'(trigger_o), 0);
      wrap_hold = 1'b0;
      step(2, 0, 0, 0);
      // R9 count write restarts phase
      step(1, 0, 0, 0);
      idle(1);
      step(3, 0, 5, 0);
      chk("R9 loaded", longint'(count_o), 5);
      idle(1);
      chk("R9 phase", longint'(count_o), 5);
      idle(1);
      chk("R9 drop", longint'(count_o), 4);
      // R12 zero period while running
      step(5, 0, 0, 0);
      chk("R12 off", longint'(mode_o), 0);
      chk("R12 count kept", longint'(count_o), 4);
      // R11 zero restart
      step(5, 0, 1, 0);
      step(3, 0, 0, 0);
      step(4, 0, 0, 0);
      step(1, 0, 0, 0);
      chk("R11 disabled", longint'(mode_o), 0);
      chk("R11 pulse", longint'(trigger_o), 1);
      step(4, 0, 4, 0);
      step(1, 0, 0, 0);
      chk("R11 loaded", longint'(count_o), 4);
      chk("R11 running", longint'(mode_o), 1);
      step(2, 0, 0, 0);
      // R10 fractional spacing, P=2, F=1/2
      step(5, 0, 2, 64'h8000_0000);
      step(3, 0, 10, 0);
      step(1, 0, 0, 0);
      idle(10);
      chk("R10 four ticks", longint'(count_o), 6);
      idle(1);
      chk("R10 stretched", longint'(count_o), 6);
      idle(1);
      chk("R10 fifth tick", longint'(count_o), 5);
      // R8 limit write while running, no reload
      step(4, 0, 7, 0);
      chk("R8 running no reload", longint'(count_o), 5);
      step(2, 0, 0, 0);
      // constrained random phase
      for (int i = 0; i < 4000; i++) begin
         int unsigned r = $urandom_range(99);
         if (r < 3) wrap_hold = ~wrap_hold;
         if (r < 84) step(0, 0, 0, 0);
         else if (r < 88) step(1, $urandom_range(1), 0, 0);
         else if (r < 90) step(2, 0, 0, 0);
         else if (r < 94) step(3, 0, $urandom_range(6), 0);
         else if (r < 97) step(4, $urandom_range(1), $urandom_range(6), 0);
         else step(5, 0, ($urandom_range(9) == 0) ? 0 : $urandom_range(1, 4), longint'($urandom));
      end
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule